// File: doc/BRIEF.md
# I2C Bit Timing Generator

This block turns single-bit requests from an I2C transaction engine into SCL and SDA waveforms on an open-drain bus. A request is a START, a STOP, a data bit to send, or a data bit to receive. Each request runs through up to three timed phases. In the first phase SCL is held low and SDA is set up. In the second phase SCL is released high. START and STOP add a third phase in which SDA moves while SCL stays high. When the request is finished the block returns to idle with SCL released.

A programmable unit count in clock cycles sets the bit period. Only the low half of the configuration word is used for it. The speed-mode code selects the low-to-high ratio: one unit low and one unit high in standard mode, or two units low and one unit high in fast mode. The block watches the real level of SCL. If a slave holds the clock low after release, the high-phase count waits for it. After such a stretch ends, a programmable number of setup cycles must also pass before the count resumes.

Both lines are driven only through drive-low enables.

Top module: `i2c_bit_timer`

## Requirements
- R1: After reset both drive-low enables are 0, bit_done is 0, and req_ready is 1 while enable is 1.
- R2: The unit count B is baud_cfg[15:0], and values below 2 are used as 2. baud_cfg[31:16] has no effect on timing.
- R3: In standard mode (speed_mode 0), a data request holds scl_drive_low for B cycles and then releases SCL for B cycles, for a busy time of 2B cycles from acceptance to bit_done.
- R4: In fast mode (speed_mode 1), a data request holds scl_drive_low for 2B cycles and then releases SCL for B cycles.
- R5: speed_mode codes 2 and 3 give the same timing as standard mode.
- R6: While SCL is released but scl_in reads 0, the high-phase count is frozen. Once scl_in reads 1 after such a stretch, setup_cycles further cycles pass before the high phase counts its B cycles.
- R7: START (req_cmd 0) takes three phases of B cycles each: SCL low with SDA released, SCL released with SDA released, then SDA driven low with SCL released. It ends with sda_drive_low 1 and scl_drive_low 0.
- R8: STOP (req_cmd 1) takes three phases of B cycles each: SCL low with SDA driven low, SCL released with SDA low, then SDA released with SCL released. It ends with both drive-low enables at 0.
- R9: A write (req_cmd 2) drives sda_drive_low to the inverse of req_bit, starting one cycle after SCL is pulled low and holding through the high phase. SDA never changes while SCL stays released, except at the start of the third phase of START or STOP.
- R10: A read (req_cmd 3) releases SDA. It samples sda_in at high-phase count floor(B/2) and presents that value on rx_bit during the bit_done cycle.
- R11: Each accepted request produces exactly one single-cycle bit_done pulse, in the cycle after its last phase ends. req_ready is 1 only when the block is idle and enabled.
- R12: While enable is 0, any request in progress is dropped and req_ready is 0. From the next cycle both drive-low enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Block enable; 0 aborts and releases the bus |
| speed_mode | input | 2 | 0 standard, 1 fast, 2 and 3 treated as standard |
| baud_cfg | input | 32 | Unit count in bits [15:0]; bits [31:16] ignored |
| setup_cycles | input | 8 | Data setup cycles after a clock stretch |
| scl_in | input | 1 | Sensed SCL level |
| sda_in | input | 1 | Sensed SDA level |
| scl_drive_low | output | 1 | 1 pulls SCL low |
| sda_drive_low | output | 1 | 1 pulls SDA low |
| req_valid | input | 1 | Bit request present |
| req_cmd | input | 2 | 0 START, 1 STOP, 2 write, 3 read |
| req_bit | input | 1 | Data bit for a write |
| req_ready | output | 1 | Request accepted this cycle when valid |
| bit_done | output | 1 | One-cycle completion pulse |
| rx_bit | output | 1 | Sampled read data, valid with bit_done |

## Verification
The bench drives a slave model that can hold SCL low for a chosen number of cycles. It checks the exact busy and low-phase lengths for every request. A design that let its high count run during a stretch, or that skipped the setup wait, would finish early. A fast mode built with the wrong ratio, or modes 2 and 3 left unmapped, would show wrong low lengths. So would a unit count below 2 left unclamped, or one that leaked the upper half of the configuration word. Reads are run with the slave both pulling SDA low and releasing it, so a sampler reading the driven value instead of the sensed line is caught. Dropping enable in the middle of a bit shows whether the lines come free within one cycle and whether a late completion pulse slips out.

// File: rtl/i2c_bt_pkg.sv
package i2c_bt_pkg;
  typedef enum logic [1:0] {
    CMD_START = 2'd0,
    CMD_STOP  = 2'd1,
    CMD_WRITE = 2'd2,
    CMD_READ  = 2'd3
  } bt_cmd_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2,
    PH_EDGE = 2'd3
  } bt_phase_e;

  localparam logic [1:0] SPD_FAST = 2'd1;
endpackage

// File: rtl/i2c_bt_period.sv
module i2c_bt_period
  import i2c_bt_pkg::*;
#(
  parameter int BAUD_W = 16,
  parameter int CFG_W  = 2 * BAUD_W
) (
  input  logic [CFG_W-1:0]  baud_cfg,
  input  logic [1:0]        speed_mode,
  output logic [BAUD_W-1:0] unit_len,
  output logic [BAUD_W:0]   data_low_len
);
  localparam logic [BAUD_W-1:0] MIN_UNIT = BAUD_W'(2);

  logic [BAUD_W-1:0] raw_unit;
  logic              unused_hi_cfg;

  assign raw_unit      = baud_cfg[BAUD_W-1:0];
  assign unused_hi_cfg = ^baud_cfg[CFG_W-1:BAUD_W];

  // a unit below two cycles would leave no room for the SDA setup step
  assign unit_len = (raw_unit < MIN_UNIT) ? MIN_UNIT : raw_unit;

  // fast mode doubles the low phase; every other code uses the standard 1:1 split
  always_comb begin
    if (speed_mode == SPD_FAST) data_low_len = {unit_len, 1'b0};
    else                        data_low_len = {1'b0, unit_len};
  end
endmodule

// File: rtl/i2c_bt_seq.sv
module i2c_bt_seq
  import i2c_bt_pkg::*;
#(
  parameter int BAUD_W  = 16,
  parameter int SETUP_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic [BAUD_W-1:0]  unit_len,
  input  logic [BAUD_W:0]    data_low_len,
  input  logic [SETUP_W-1:0] setup_cycles,
  input  logic               scl_in,
  input  logic               sda_in,
  input  logic               req_valid,
  input  logic [1:0]         req_cmd,
  input  logic               req_bit,
  output logic               req_ready,
  output logic               scl_drive_low,
  output logic               sda_drive_low,
  output logic               bit_done,
  output logic               rx_bit,
  output logic               phase_edge
);
  localparam int CW = BAUD_W + 1;

  bt_phase_e          phase_q, phase_d;
  bt_cmd_e            cmd_q, cmd_d;
  logic               bit_q, bit_d;
  logic [CW-1:0]      cnt_q, cnt_d, cnt_inc;
  logic [SETUP_W-1:0] scnt_q, scnt_d;
  logic               scl_q, scl_d;
  logic               sda_q, sda_d;
  logic               rx_q, rx_d;
  logic               done_q, done_d;

  logic [CW-1:0] unit_ext, half_pt, low_target;
  logic          data_cmd;
  logic          sda_first;

  assign unit_ext   = {1'b0, unit_len};
  assign half_pt    = unit_ext >> 1;
  assign cnt_inc    = cnt_q + CW'(1);
  assign data_cmd   = (cmd_q == CMD_WRITE) || (cmd_q == CMD_READ);
  assign low_target = data_cmd ? data_low_len : unit_ext;

  // SDA level chosen for the clock-low phase of each request
  always_comb begin
    case (cmd_q)
      CMD_STOP:  sda_first = 1'b1;
      CMD_WRITE: sda_first = ~bit_q;
      default:   sda_first = 1'b0;
    endcase
  end

  always_comb begin
    phase_d = phase_q;
    cmd_d   = cmd_q;
    bit_d   = bit_q;
    cnt_d   = cnt_q;
    scnt_d  = scnt_q;
    scl_d   = scl_q;
    sda_d   = sda_q;
    rx_d    = rx_q;
    done_d  = 1'b0;
    if (!enable) begin
      phase_d = PH_IDLE;
      cnt_d   = '0;
      scnt_d  = '0;
      scl_d   = 1'b0;
      sda_d   = 1'b0;
    end else begin
      case (phase_q)
        PH_IDLE: begin
          if (req_valid) begin
            cmd_d   = bt_cmd_e'(req_cmd);
            bit_d   = req_bit;
            phase_d = PH_LOW;
            cnt_d   = '0;
            scl_d   = 1'b1;
          end
        end
        PH_LOW: begin
          cnt_d = cnt_inc;
          // SDA moves one cycle after SCL has gone low
          if (cnt_q == '0) sda_d = sda_first;
          if (cnt_inc == low_target) begin
            phase_d = PH_HIGH;
            cnt_d   = '0;
            scnt_d  = '0;
            scl_d   = 1'b0;
          end
        end
        PH_HIGH: begin
          if (!scl_in) begin
            scnt_d = setup_cycles;
          end else if (scnt_q != '0) begin
            scnt_d = scnt_q - SETUP_W'(1);
          end else begin
            cnt_d = cnt_inc;
            if (data_cmd && (cnt_q == half_pt)) rx_d = sda_in;
            if (cnt_inc == unit_ext) begin
              cnt_d = '0;
              if (data_cmd) begin
                phase_d = PH_IDLE;
                done_d  = 1'b1;
              end else begin
                phase_d = PH_EDGE;
                sda_d   = (cmd_q == CMD_START);
              end
            end
          end
        end
        default: begin
          cnt_d = cnt_inc;
          if (cnt_inc == unit_ext) begin
            cnt_d   = '0;
            phase_d = PH_IDLE;
            done_d  = 1'b1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cmd_q   <= CMD_START;
      bit_q   <= 1'b0;
      cnt_q   <= '0;
      scnt_q  <= '0;
      scl_q   <= 1'b0;
      sda_q   <= 1'b0;
      rx_q    <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cmd_q   <= cmd_d;
      bit_q   <= bit_d;
      cnt_q   <= cnt_d;
      scnt_q  <= scnt_d;
      scl_q   <= scl_d;
      sda_q   <= sda_d;
      rx_q    <= rx_d;
      done_q  <= done_d;
    end
  end

  assign req_ready     = enable && (phase_q == PH_IDLE);
  assign scl_drive_low = scl_q;
  assign sda_drive_low = sda_q;
  assign bit_done      = done_q;
  assign rx_bit        = rx_q;
  assign phase_edge    = (phase_q == PH_EDGE);
endmodule

// File: rtl/i2c_bit_timer.sv
module i2c_bit_timer #(
  parameter int BAUD_W  = 16,
  parameter int CFG_W   = 2 * BAUD_W,
  parameter int SETUP_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic [1:0]         speed_mode,
  input  logic [CFG_W-1:0]   baud_cfg,
  input  logic [SETUP_W-1:0] setup_cycles,
  input  logic               scl_in,
  input  logic               sda_in,
  output logic               scl_drive_low,
  output logic               sda_drive_low,
  input  logic               req_valid,
  input  logic [1:0]         req_cmd,
  input  logic               req_bit,
  output logic               req_ready,
  output logic               bit_done,
  output logic               rx_bit
);
  logic [BAUD_W-1:0] unit_len;
  logic [BAUD_W:0]   data_low_len;
  logic              phase_edge;

  i2c_bt_period #(.BAUD_W(BAUD_W), .CFG_W(CFG_W)) u_period (
    .baud_cfg     (baud_cfg),
    .speed_mode   (speed_mode),
    .unit_len     (unit_len),
    .data_low_len (data_low_len)
  );

  i2c_bt_seq #(.BAUD_W(BAUD_W), .SETUP_W(SETUP_W)) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .enable        (enable),
    .unit_len      (unit_len),
    .data_low_len  (data_low_len),
    .setup_cycles  (setup_cycles),
    .scl_in        (scl_in),
    .sda_in        (sda_in),
    .req_valid     (req_valid),
    .req_cmd       (req_cmd),
    .req_bit       (req_bit),
    .req_ready     (req_ready),
    .scl_drive_low (scl_drive_low),
    .sda_drive_low (sda_drive_low),
    .bit_done      (bit_done),
    .rx_bit        (rx_bit),
    .phase_edge    (phase_edge)
  );
endmodule

// File: rtl/i2c_bit_timer_chk.sv
module i2c_bit_timer_chk #(
  parameter int BAUD_W = 16,
  parameter int CFG_W  = 2 * BAUD_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic [1:0]       speed_mode,
  input logic [CFG_W-1:0] baud_cfg,
  input logic             scl_drive_low,
  input logic             sda_drive_low,
  input logic             req_ready,
  input logic             bit_done,
  input logic             phase_edge
);
  logic [BAUD_W+1:0] low_run;
  logic [BAUD_W+1:0] unit_chk;
  logic [BAUD_W+1:0] fast_chk;
  logic              unused_cfg;

  assign unused_cfg = ^baud_cfg[CFG_W-1:BAUD_W];
  assign unit_chk   = (baud_cfg[BAUD_W-1:0] < BAUD_W'(2)) ? (BAUD_W+2)'(2)
                                                           : (BAUD_W+2)'(baud_cfg[BAUD_W-1:0]);
  assign fast_chk   = (speed_mode == 2'd1) ? (unit_chk << 1) : unit_chk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             low_run <= '0;
    else if (scl_drive_low) low_run <= low_run + 1'b1;
    else                    low_run <= '0;
  end

  AST_LOW_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(scl_drive_low) && $past(enable)) |-> (low_run == unit_chk || low_run == fast_chk)); // R4

  AST_SDA_STABLE_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_drive_low) && !scl_drive_low && !$past(scl_drive_low) && $past(enable)) |-> phase_edge); // R9

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    bit_done |=> !bit_done); // R11

  AST_READY_SCL_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !scl_drive_low); // R11

  AST_DISABLE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!scl_drive_low && !sda_drive_low)); // R12
endmodule

bind i2c_bit_timer i2c_bit_timer_chk #(.BAUD_W(BAUD_W), .CFG_W(CFG_W)) i_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .enable        (enable),
  .speed_mode    (speed_mode),
  .baud_cfg      (baud_cfg),
  .scl_drive_low (scl_drive_low),
  .sda_drive_low (sda_drive_low),
  .req_ready     (req_ready),
  .bit_done      (bit_done),
  .phase_edge    (phase_edge)
);

// File: tb/test_i2c_bit_timer.sv
module test_i2c_bit_timer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        enable;
  logic [1:0]  speed_mode;
  logic [31:0] baud_cfg;
  logic [7:0]  setup_cycles;
  logic        scl_in, sda_in;
  logic        scl_drive_low, sda_drive_low;
  logic        req_valid;
  logic [1:0]  req_cmd;
  logic        req_bit;
  logic        req_ready, bit_done, rx_bit;

  logic slave_sda = 1'b1;
  logic scl_hold  = 1'b0;
  int   hold_left = 0;
  int   stretch_n = 0;
  logic prev_scl  = 1'b0;

  int n_chk = 0;
  int n_bad = 0;
  int busy_cnt = 0;
  int low_cnt = 0;

  typedef struct {
    int tag;
    int busy;
    int low;
    bit rx_chk;
    bit rx;
    bit sda;
  } exp_t;
  exp_t exp_q[$];

  always #4 clk = ~clk;

  assign scl_in = ~scl_drive_low & ~scl_hold;
  assign sda_in = ~sda_drive_low & slave_sda;

  i2c_bit_timer i_i2c_bit_timer (
    .clk (clk), .rst_n (rst_n), .enable (enable), .speed_mode (speed_mode),
    .baud_cfg (baud_cfg), .setup_cycles (setup_cycles), .scl_in (scl_in),
    .sda_in (sda_in), .scl_drive_low (scl_drive_low), .sda_drive_low (sda_drive_low),
    .req_valid (req_valid), .req_cmd (req_cmd), .req_bit (req_bit),
    .req_ready (req_ready), .bit_done (bit_done), .rx_bit (rx_bit)
  );

  task automatic chk(input int req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL R%0d: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // slave model: holds SCL low for stretch_n cycles after the master releases it
  always @(negedge clk) begin
    if (prev_scl && !scl_drive_low && stretch_n > 0) begin
      scl_hold  = 1'b1;
      hold_left = stretch_n;
      stretch_n = 0;
    end else if (scl_hold) begin
      if (hold_left <= 1) scl_hold = 1'b0;
      else                hold_left--;
    end
    prev_scl = scl_drive_low;
  end

  // monitor: measures each request and compares with the scoreboard head
  always @(negedge clk) begin
    if (!rst_n || !enable) begin
      busy_cnt = 0;
      low_cnt  = 0;
    end else if (bit_done) begin
      if (exp_q.size() == 0) begin
        chk(11, 1, 0); // R11 unexpected completion
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(e.tag, busy_cnt, e.busy);
        chk(e.tag, low_cnt, e.low);
        chk(e.tag, int'(sda_drive_low), int'(e.sda));
        chk(e.tag, int'(scl_drive_low), 0);
        if (e.rx_chk) chk(e.tag, int'(rx_bit), int'(e.rx));
      end
      busy_cnt = 0;
      low_cnt  = 0;
    end else begin
      if (!req_ready)    busy_cnt++;
      if (scl_drive_low) low_cnt++;
    end
  end

  task automatic run_op(input int tag, input logic [1:0] cmd, input logic b, input int s);
    exp_t e;
    int   unit, lowlen, hi;
    unit   = (baud_cfg[15:0] < 2) ? 2 : int'(baud_cfg[15:0]);
    lowlen = (cmd >= 2'd2 && speed_mode == 2'd1) ? 2 * unit : unit;
    hi     = unit + ((s > 0) ? s + int'(setup_cycles) : 0);
    e.tag    = tag;
    e.low    = lowlen;
    e.busy   = (cmd >= 2'd2) ? lowlen + hi : lowlen + hi + unit;
    e.rx_chk = (cmd == 2'd3);
    e.rx     = slave_sda;
    case (cmd)
      2'd0:    e.sda = 1'b1;
      2'd2:    e.sda = ~b;
      default: e.sda = 1'b0;
    endcase
    exp_q.push_back(e);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    stretch_n = s;
    req_valid = 1'b1;
    req_cmd   = cmd;
    req_bit   = b;
    @(negedge clk);
    req_valid = 1'b0;
    chk(11, int'(req_ready), 0); // R11 busy after acceptance
    while (!bit_done) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; enable = 1'b1; speed_mode = 2'd0; baud_cfg = 32'd4;
    setup_cycles = 8'd3; req_valid = 1'b0; req_cmd = 2'd0; req_bit = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(1, int'(scl_drive_low), 0);
    chk(1, int'(sda_drive_low), 0);
    chk(1, int'(bit_done), 0);
    chk(1, int'(req_ready), 1);

    // standard mode, unit 4: R7 START, R3 and R9 writes, R10 reads, R8 STOP
    run_op(7, 2'd0, 1'b0, 0);
    run_op(3, 2'd2, 1'b1, 0);
    run_op(9, 2'd2, 1'b0, 0);
    slave_sda = 1'b1; run_op(10, 2'd3, 1'b0, 0);
    slave_sda = 1'b0; run_op(10, 2'd3, 1'b0, 0);
    slave_sda = 1'b1; run_op(8, 2'd1, 1'b0, 0);

    // fast mode, upper config half filled with junk: R4 and R2
    speed_mode = 2'd1; baud_cfg = 32'hABCD_0005;
    run_op(4, 2'd0, 1'b0, 0);
    run_op(4, 2'd2, 1'b1, 0);
    slave_sda = 1'b0; run_op(2, 2'd3, 1'b0, 0);
    slave_sda = 1'b1; run_op(4, 2'd1, 1'b0, 0);

    // reserved speed codes fall back to standard: R5
    speed_mode = 2'd3; baud_cfg = 32'd3;
    run_op(5, 2'd2, 1'b0, 0);
    speed_mode = 2'd2;
    run_op(5, 2'd2, 1'b1, 0);

    // unit below two clamps to two: R2
    speed_mode = 2'd0; baud_cfg = 32'h0000_0001;
    run_op(2, 2'd2, 1'b1, 0);

    // clock stretching with data setup: R6
    baud_cfg = 32'd4; setup_cycles = 8'd3;
    run_op(6, 2'd2, 1'b1, 5);
    slave_sda = 1'b1; run_op(6, 2'd3, 1'b0, 2);
    run_op(6, 2'd0, 1'b0, 3);
    speed_mode = 2'd1; baud_cfg = 32'd3; setup_cycles = 8'd0;
    run_op(6, 2'd2, 1'b0, 4);

    // disable in the middle of a bit: R12
    speed_mode = 2'd0; baud_cfg = 32'd6; setup_cycles = 8'd2;
    @(negedge clk);
    req_valid = 1'b1; req_cmd = 2'd1; req_bit = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (2) @(negedge clk);
    chk(12, int'(scl_drive_low), 1);
    enable = 1'b0;
    @(negedge clk);
    chk(12, int'(scl_drive_low), 0);
    chk(12, int'(sda_drive_low), 0);
    chk(12, int'(req_ready), 0);
    repeat (20) @(negedge clk);
    chk(12, int'(bit_done), 0);
    enable = 1'b1;
    run_op(12, 2'd0, 1'b0, 0);
    run_op(12, 2'd1, 1'b0, 0);

    repeat (3) @(negedge clk);
    chk(11, exp_q.size(), 0); // R11 every request completed once
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL R11: actual=hung expected=complete");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule